// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs one repeated string primitive from start to finish. A one-cycle start pulse latches the primitive (move, compare, scan, load or store), a repeat condition, an element width, a stepping direction, two start pointers (source and destination), a repeat count and an accumulator value. The sequencer then issues element reads and writes on a simple request/acknowledge memory port. After each element it steps the pointers and counts down. It ends when the count reaches zero, or, for compare and scan, when the chosen zero-flag or carry-flag condition no longer holds.

The controller is a state machine with seven states. In IDLE it waits for start (IDLE→TEST). TEST checks the count: zero goes to FIN. A nonzero count goes to the first access state of the primitive: RD_SRC for move, compare and load; RD_DST for scan; WR_DST for store. RD_SRC moves on when acknowledged: to WR_DST for move, to RD_DST for compare, to STEP for load. RD_DST and WR_DST move to STEP when acknowledged. STEP decrements the count and steps the pointers. It then goes either back to the primitive's first access state or to FIN. FIN pulses done and returns to IDLE.

The final pointers, count, accumulator and flags stay on the outputs after done. A caller can chain repeats or read the point where a scan or compare stopped.

Top module: `strop_rep_seq`

## Requirements
- R1: After reset, busy, done and mem_req are low, and src_ptr, dst_ptr, cnt, acc, zf and cf are all zero.
- R2: A start pulse seen while idle latches op_sel, rep_sel, elem_size, dir_down and the four initial values. A start pulse while busy is ignored and does not change the run in progress.
- R3: When the latched count is zero, no memory request is made and done follows. Pointers and accumulator keep their start values.
- R4: Element width elem_size 0, 1, 2 selects 1, 2 or 4 bytes (3 acts as 4). After each element the pointers step by that many bytes: upward when dir_down is 0, downward when it is 1. Move and compare step both pointers, load steps only the source, and scan and store step only the destination.
- R5: Each completed element lowers cnt by exactly one. When no flag condition stops the run, exactly the start count of elements is processed and cnt ends at zero.
- R6: A request stays asserted with stable address and write strobe until mem_ack. Data travels in the low element-width bits of mem_rdata/mem_wdata, and mem_size carries elem_size. Move reads the source element, then writes it to the destination.
- R7: Compare (op_sel 1) reads source then destination. It sets zf when the two are equal at element width, and cf when source is unsigned-below destination.
- R8: Scan (op_sel 2) compares the low element-width bits of acc with each destination element. zf shows equality and cf shows acc unsigned-below the element.
- R9: Load (op_sel 3) replaces the low element-width bits of acc with the source element and keeps the upper bits. Store (op_sel 4) writes acc's low element-width bits to the destination.
- R10: rep_sel 0 repeats on count alone. For compare and scan only, rep_sel 1 continues while zf=1, 2 while zf=0, 3 while cf=1, 4 while cf=0. The test runs after the element's count decrement. For move, load and store the repeat condition has no effect.
- R11: Move, load and store leave zf and cf unchanged.
- R12: done is high for exactly one cycle at the end of a run, with final values valid on the outputs in that cycle. busy drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled in IDLE |
| op_sel | input | 3 | Primitive: 0 move, 1 compare, 2 scan, 3 load, 4 store |
| rep_sel | input | 3 | Repeat condition, 0..4 as in R10 |
| elem_size | input | 2 | Element width code |
| dir_down | input | 1 | 1 steps pointers downward |
| src_init | input | AW | Initial source pointer |
| dst_init | input | AW | Initial destination pointer |
| cnt_init | input | CW | Initial repeat count |
| acc_init | input | DW | Initial accumulator |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of element |
| mem_wdata | output | DW | Write data, low bits significant |
| mem_size | output | 2 | Element width of access |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| cnt | output | CW | Current remaining count |
| acc | output | DW | Accumulator |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry (borrow) flag |

## Verification
A wrong step width, direction or step enable shows in the final src_ptr or dst_ptr at the done pulse. Before that it shows as a shifted mem_addr on the second element request, one element after the fault. A count or termination fault changes the number of acknowledged accesses and the final cnt, and flag errors show on zf and cf as soon as the first compare or scan element completes. Data-path faults show in the bytes written to memory or in acc, and the bench compares every memory byte after each run.

// File: rtl/strop_pkg.sv
`timescale 1ns/1ps
package strop_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_CMP   = 3'd1,
        OP_SCAN  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } strop_op_e;

    typedef enum logic [2:0] {
        RP_PLAIN    = 3'd0,
        RP_WHILE_Z  = 3'd1,
        RP_WHILE_NZ = 3'd2,
        RP_WHILE_C  = 3'd3,
        RP_WHILE_NC = 3'd4
    } strop_rep_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEST,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WR_DST,
        ST_STEP,
        ST_FIN
    } strop_state_e;

    function automatic strop_op_e op_decode(input logic [2:0] code);
        case (code)
            3'd1:    return OP_CMP;
            3'd2:    return OP_SCAN;
            3'd3:    return OP_LOAD;
            3'd4:    return OP_STORE;
            default: return OP_MOVE;
        endcase
    endfunction

    function automatic strop_rep_e rep_decode(input logic [2:0] code);
        case (code)
            3'd1:    return RP_WHILE_Z;
            3'd2:    return RP_WHILE_NZ;
            3'd3:    return RP_WHILE_C;
            3'd4:    return RP_WHILE_NC;
            default: return RP_PLAIN;
        endcase
    endfunction

    function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic strop_state_e first_state(input strop_op_e op);
        case (op)
            OP_SCAN:  return ST_RD_DST;
            OP_STORE: return ST_WR_DST;
            default:  return ST_RD_SRC;
        endcase
    endfunction

endpackage

// File: rtl/strop_ptr_step.sv
`timescale 1ns/1ps
module strop_ptr_step import strop_pkg::*; #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    size,
    input  logic          down,
    input  logic          en,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step;

    assign step = AW'(elem_bytes(size));

    always_comb begin
        if (!en) begin
            nxt = cur;
        end else if (down) begin
            nxt = cur - step;
        end else begin
            nxt = cur + step;
        end
    end
endmodule

// File: rtl/strop_flag_calc.sv
`timescale 1ns/1ps
module strop_flag_calc #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic [1:0]    size,
    output logic [DW-1:0] mask,
    output logic          zf,
    output logic          cf
);
    logic [DW:0] diff;

    always_comb begin
        mask = '0;
        case (size)
            2'd0:    mask[7:0]  = '1;
            2'd1:    mask[15:0] = '1;
            default: mask       = '1;
        endcase
    end

    assign diff = {1'b0, lhs & mask} - {1'b0, rhs & mask};
    assign cf   = diff[DW];
    assign zf   = (diff[DW-1:0] == '0);
endmodule

// File: rtl/strop_term_eval.sv
`timescale 1ns/1ps
module strop_term_eval import strop_pkg::*; (
    input  strop_rep_e rep,
    input  logic       flag_elem,
    input  logic       zf,
    input  logic       cf,
    input  logic       left_zero,
    output logic       cont
);
    logic cond;

    always_comb begin
        cond = 1'b1;
        if (flag_elem) begin
            case (rep)
                RP_WHILE_Z:  cond = zf;
                RP_WHILE_NZ: cond = !zf;
                RP_WHILE_C:  cond = cf;
                RP_WHILE_NC: cond = !cf;
                default:     cond = 1'b1;
            endcase
        end
        cont = !left_zero && cond;
    end
endmodule

// File: rtl/strop_rep_seq.sv
`timescale 1ns/1ps
module strop_rep_seq import strop_pkg::*; #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_sel,
    input  logic [2:0]    rep_sel,
    input  logic [1:0]    elem_size,
    input  logic          dir_down,
    input  logic [AW-1:0] src_init,
    input  logic [AW-1:0] dst_init,
    input  logic [CW-1:0] cnt_init,
    input  logic [DW-1:0] acc_init,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [1:0]    mem_size,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] cnt,
    output logic [DW-1:0] acc,
    output logic          zf,
    output logic          cf
);
    strop_state_e st_q, st_d;
    strop_op_e    op_q;
    strop_rep_e   rep_q;
    logic [1:0]    size_q;
    logic          down_q;
    logic [AW-1:0] src_q, dst_q, src_nxt, dst_nxt;
    logic [CW-1:0] cnt_q, cnt_dec;
    logic [DW-1:0] acc_q, tmp_q, mask, cmp_lhs;
    logic          zf_q, cf_q, zf_new, cf_new;
    logic          cont, src_en, dst_en, is_flag_op;

    assign is_flag_op = (op_q == OP_CMP) || (op_q == OP_SCAN);
    assign src_en     = (op_q == OP_MOVE) || (op_q == OP_CMP) || (op_q == OP_LOAD);
    assign dst_en     = (op_q != OP_LOAD);
    assign cnt_dec    = cnt_q - CW'(1);
    assign cmp_lhs    = (op_q == OP_SCAN) ? acc_q : tmp_q;

    strop_ptr_step #(.AW(AW)) u_src_step (
        .cur(src_q), .size(size_q), .down(down_q), .en(src_en), .nxt(src_nxt)
    );

    strop_ptr_step #(.AW(AW)) u_dst_step (
        .cur(dst_q), .size(size_q), .down(down_q), .en(dst_en), .nxt(dst_nxt)
    );

    strop_flag_calc #(.DW(DW)) u_flags (
        .lhs(cmp_lhs), .rhs(mem_rdata), .size(size_q),
        .mask(mask), .zf(zf_new), .cf(cf_new)
    );

    strop_term_eval u_term (
        .rep(rep_q), .flag_elem(is_flag_op), .zf(zf_q), .cf(cf_q),
        .left_zero(cnt_dec == '0), .cont(cont)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_TEST;
            ST_TEST:   st_d = (cnt_q == '0) ? ST_FIN : first_state(op_q);
            ST_RD_SRC: begin
                if (mem_ack) begin
                    if (op_q == OP_MOVE)     st_d = ST_WR_DST;
                    else if (op_q == OP_CMP) st_d = ST_RD_DST;
                    else                     st_d = ST_STEP;
                end
            end
            ST_RD_DST: if (mem_ack) st_d = ST_STEP;
            ST_WR_DST: if (mem_ack) st_d = ST_STEP;
            ST_STEP:   st_d = cont ? first_state(op_q) : ST_FIN;
            ST_FIN:    st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = src_q;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (st_q)
            ST_RD_SRC: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            ST_RD_DST: begin
                mem_req  = 1'b1;
                mem_addr = dst_q;
            end
            ST_WR_DST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = (op_q == OP_STORE) ? acc_q : tmp_q;
            end
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end

    assign busy     = (st_q != ST_IDLE);
    assign mem_size = size_q;
    assign src_ptr  = src_q;
    assign dst_ptr  = dst_q;
    assign cnt      = cnt_q;
    assign acc      = acc_q;
    assign zf       = zf_q;
    assign cf       = cf_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_MOVE;
            rep_q  <= RP_PLAIN;
            size_q <= '0;
            down_q <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            acc_q  <= '0;
            tmp_q  <= '0;
            zf_q   <= 1'b0;
            cf_q   <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && start) begin
                op_q   <= op_decode(op_sel);
                rep_q  <= rep_decode(rep_sel);
                size_q <= elem_size;
                down_q <= dir_down;
                src_q  <= src_init;
                dst_q  <= dst_init;
                cnt_q  <= cnt_init;
                acc_q  <= acc_init;
            end
            if (st_q == ST_RD_SRC && mem_ack) begin
                if (op_q == OP_LOAD) acc_q <= (acc_q & ~mask) | (mem_rdata & mask);
                else                 tmp_q <= mem_rdata & mask;
            end
            if (st_q == ST_RD_DST && mem_ack) begin
                zf_q <= zf_new;
                cf_q <= cf_new;
            end
            if (st_q == ST_STEP) begin
                cnt_q <= cnt_dec;
                src_q <= src_nxt;
                dst_q <= dst_nxt;
            end
        end
    end

    // assertions
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TEST && cnt_q == '0) |=> (done && !mem_req));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (cnt != $past(cnt))) |-> (cnt == $past(cnt) - CW'(1)));

    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_flag_op) |=> ($stable(zf) && $stable(cf)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && start) |=> $stable(op_q));
endmodule

// File: tb/strop_rep_seq_tb_top.sv
`timescale 1ns/1ps
module strop_rep_seq_tb_top;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op_sel = '0;
    logic [2:0]    rep_sel = '0;
    logic [1:0]    elem_size = '0;
    logic          dir_down = 1'b0;
    logic [AW-1:0] src_init = '0;
    logic [AW-1:0] dst_init = '0;
    logic [CW-1:0] cnt_init = '0;
    logic [DW-1:0] acc_init = '0;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [1:0]    mem_size;
    logic          busy, done, zf, cf;
    logic [AW-1:0] src_ptr, dst_ptr;
    logic [CW-1:0] cnt;
    logic [DW-1:0] acc;

    logic       ack_en = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic       fill_req = 1'b0;
    int         fill_seed = 0;
    int         n_acc = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    logic       exp_zf = 1'b0;
    logic       exp_cf = 1'b0;

    strop_rep_seq #(.AW(AW), .CW(CW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .rep_sel(rep_sel),
        .elem_size(elem_size), .dir_down(dir_down), .src_init(src_init),
        .dst_init(dst_init), .cnt_init(cnt_init), .acc_init(acc_init),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_size(mem_size), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .cnt(cnt), .acc(acc), .zf(zf), .cf(cf)
    );

    always #2 clk = ~clk;

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [7:0] pat(input int idx, input int seed);
        int sel;
        sel = ((idx >> 2) + seed) % 3;
        return (sel == 0) ? 8'h3C : (sel == 1) ? 8'h00 : 8'h7E;
    endfunction

    assign mem_ack = mem_req & ack_en;

    always @(negedge clk) begin
        lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ack_en <= (lfsr[1:0] != 2'b00);
    end

    always_comb begin
        mem_rdata = '0;
        for (int k = 0; k < 4; k++)
            if (k < nbytes(mem_size)) mem_rdata[8*k +: 8] = mem[mem_addr[7:0] + 8'(k)];
    end

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i, fill_seed);
        end else if (mem_req && mem_we && mem_ack) begin
            for (int k = 0; k < 4; k++)
                if (k < nbytes(mem_size)) mem[mem_addr[7:0] + 8'(k)] <= mem_wdata[8*k +: 8];
        end
        if (mem_req && mem_ack) n_acc <= n_acc + 1;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [15:0] a, input int nb);
        logic [31:0] v = '0;
        for (int k = 0; k < nb; k++) v[8*k +: 8] = exp_mem[a[7:0] + 8'(k)];
        return v;
    endfunction

    task automatic exp_wr(input logic [15:0] a, input int nb, input logic [31:0] v);
        for (int k = 0; k < nb; k++) exp_mem[a[7:0] + 8'(k)] = v[8*k +: 8];
    endtask

    task automatic do_fill(input int seed);
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i, seed);
        fill_seed = seed;
        fill_req  = 1'b1;
        @(negedge clk);
        fill_req  = 1'b0;
    endtask

    // expected behaviour from R3..R11
    task automatic model(input int op, input int rep, input int es, input int dn,
                         input logic [15:0] s0, input logic [15:0] d0, input int c0,
                         input logic [31:0] a0,
                         output logic [15:0] s, output logic [15:0] d, output int c,
                         output logic [31:0] a, output int nacc);
        int nb;
        logic [31:0] m, x, y;
        bit stop;
        nb = (es == 0) ? 1 : (es == 1) ? 2 : 4;
        m  = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        s = s0; d = d0; c = c0; a = a0; nacc = 0; stop = 1'b0;
        while (c != 0 && !stop) begin
            x = '0; y = '0;
            case (op)
                0: begin x = exp_rd(s, nb); exp_wr(d, nb, x); nacc += 2; end
                1: begin x = exp_rd(s, nb); y = exp_rd(d, nb); nacc += 2; end
                2: begin x = a & m; y = exp_rd(d, nb); nacc += 1; end
                3: begin a = (a & ~m) | exp_rd(s, nb); nacc += 1; end
                default: begin exp_wr(d, nb, a & m); nacc += 1; end
            endcase
            if (op == 1 || op == 2) begin
                exp_zf = (x == y);
                exp_cf = (x < y);
            end
            c--;
            if (op == 0 || op == 1 || op == 3) s = dn ? s - 16'(nb) : s + 16'(nb);
            if (op != 3) d = dn ? d - 16'(nb) : d + 16'(nb);
            if (op == 1 || op == 2) begin
                case (rep)
                    1: stop = !exp_zf;
                    2: stop = exp_zf;
                    3: stop = !exp_cf;
                    4: stop = exp_cf;
                    default: stop = 1'b0;
                endcase
            end
        end
    endtask

    task automatic run_case(input int op, input int rep, input int es, input int dn,
                            input int c0, input int seed, input bit poke);
        logic [15:0] s0, d0, es_s, es_d;
        logic [31:0] a0, ea;
        int ec, enacc, acc_before, waited, mism;
        string ctag, ftag, atag, mtag;
        do_fill(seed);
        s0 = dn ? 16'h007C : 16'h0040;
        d0 = dn ? 16'h00BC : 16'h0080;
        a0 = (seed == 0) ? 32'h3C3C_3C3C : (seed == 1) ? 32'h0000_0000 : 32'hA1B2_C300;
        model(op, rep, es, dn, s0, d0, c0, a0, es_s, es_d, ec, ea, enacc);
        acc_before = n_acc;
        start = 1'b1; op_sel = 3'(op); rep_sel = 3'(rep); elem_size = 2'(es);
        dir_down = dn[0]; src_init = s0; dst_init = d0; cnt_init = CW'(c0); acc_init = a0;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start = 1'b1; op_sel = 3'd4; cnt_init = CW'(2); acc_init = 32'hFFFF_FFFF;
            src_init = '0; dst_init = '0; elem_size = 2'd2;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 400, "R12", "done seen", longint'(waited), 64'd0);
        ctag = ((op == 1 || op == 2) && rep != 0) ? "R10" : "R5";
        ftag = (op == 1) ? "R7" : (op == 2) ? "R8" : "R11";
        atag = (c0 == 0) ? "R3" : "R6";
        mtag = (op == 4) ? "R9" : "R6";
        chk(src_ptr == es_s, "R4", "src_ptr", longint'(src_ptr), longint'(es_s));
        chk(dst_ptr == es_d, "R4", "dst_ptr", longint'(dst_ptr), longint'(es_d));
        chk(cnt == CW'(ec), ctag, "cnt", longint'(cnt), longint'(ec));
        chk(acc == ea, "R9", "acc", longint'(acc), longint'(ea));
        chk(zf == exp_zf && cf == exp_cf, ftag, "flags zf,cf",
            longint'({zf, cf}), longint'({exp_zf, exp_cf}));
        chk((n_acc - acc_before) == enacc, atag, "access count",
            longint'(n_acc - acc_before), longint'(enacc));
        if (poke) chk(cnt == CW'(ec) && src_ptr == es_s && acc == ea, "R2",
                      "start while busy", longint'(cnt), longint'(ec));
        @(negedge clk);
        chk(!done && !busy, "R12", "done/busy after pulse",
            longint'({done, busy}), 64'd0);
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
        chk(mism == 0, mtag, "memory bytes differing", longint'(mism), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_req, "R1", "busy,done,req",
            longint'({busy, done, mem_req}), 64'd0);
        chk(src_ptr == '0 && dst_ptr == '0 && cnt == '0, "R1", "pointers,count",
            longint'({src_ptr, dst_ptr, cnt}), 64'd0);
        chk(acc == '0 && !zf && !cf, "R1", "acc,flags", longint'(acc), 64'd0);
        for (int op = 0; op < 5; op++)
            for (int rep = 0; rep < 5; rep++)
                for (int es = 0; es < 3; es++)
                    for (int dn = 0; dn < 2; dn++)
                        for (int ci = 0; ci < 4; ci++) begin
                            int c0 = (ci == 0) ? 0 : (ci == 1) ? 1 : (ci == 2) ? 3 : 5;
                            run_case(op, rep, es, dn, c0, (op + rep + c0 + dn) % 3,
                                     (c0 == 5 && dn == 1 && rep == 0));
                        end
        // R4: width code 3 behaves as 4 bytes
        for (int op = 0; op < 5; op++) run_case(op, 0, 3, op % 2, 3, op % 3, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule